// File: doc/BRIEF.md
# Centisecond Stopwatch with Min/Max Record

This block counts elapsed time in hundredths of a second and shows it as four BCD digits: two digits of seconds (00 to 99), then tenths and hundredths. The decimal point between seconds and fractions is always lit. A 100 Hz tick pulse from outside paces the count. A level input selects between operate mode, where an action pulse starts and stops the count and a clear pulse zeroes it, and history mode, where a two-bit command tells the action pulse what to do with a record of the shortest and longest saved times.

In history mode the current time can be saved into the record, the record can be wiped, or the stored shortest and longest values can be viewed one at a time, each action pulse switching between them. While viewing, a flag output tells whether the longest (1) or the shortest (0) value is on the digits. Debouncing, tick generation and segment driving are handled elsewhere. All inputs are synchronous one-cycle pulses or levels, and every effect appears on the outputs after the clock edge that samples the input.

Top module: `stopwatch_hist`

## Requirements
- R1: After reset the time, both stored values and the view flag are zero, the count is stopped, the digits read 00.00, and `dp_on` is 1.
- R2: While running, each cycle with `tick` high adds one hundredth. `digits[3:0]` holds hundredths, `[7:4]` tenths, `[11:8]` seconds units and `[15:12]` seconds tens, with decimal carries between them.
- R3: In operate mode (`hist_mode`=0) each `action` pulse toggles between running and stopped. A restart continues from the held value, and ticks have no effect while stopped.
- R4: A `clear` pulse sets the time to 00.00 in the next cycle and wins over a simultaneous tick. It leaves the run state unchanged.
- R5: A running count at 99.99 goes to 00.00 on the next tick.
- R6: When the record is empty (after reset or a wipe), an `action` with `hist_mode`=1 and `hist_cmd`=00 (save) loads the current time into both the shortest and the longest value.
- R7: Any later save replaces the longest value if the current time is greater, and the shortest value if it is smaller. The comparison uses all four digits.
- R8: An `action` with `hist_cmd`=01 (wipe) zeroes both stored values, marks the record empty, and resets the view flag to 0.
- R9: An `action` with `hist_cmd`=10 (view) toggles `show_max`. While `hist_mode`=1 and `hist_cmd`=10, the digits show the longest value when `show_max`=1 and the shortest value otherwise. In every other case they show the current time.
- R10: An `action` with `hist_cmd`=11 changes nothing. History-mode actions never change the run state, so a running count keeps counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse at 100 Hz |
| hist_mode | input | 1 | 0 = operate, 1 = history |
| hist_cmd | input | 2 | History command: 00 save, 01 wipe, 10 view, 11 none |
| action | input | 1 | One-cycle action button pulse |
| clear | input | 1 | One-cycle clear button pulse |
| digits | output | 16 | Four BCD digits, seconds tens in the top nibble |
| dp_on | output | 1 | Decimal point enable |
| show_max | output | 1 | View selection: 1 = longest value, 0 = shortest |

## Verification
Every state change (count, run toggle, clear, record update, view toggle) is due one cycle after the edge that samples the stimulus. The display source follows the mode and command levels with no delay, because it is a combinational selection of registered values. The bench drives inputs on the falling edge and updates its reference model just after the next rising edge. It then compares digits, decimal point and view flag on the following falling edge, so every sampled value is a settled registered result. The reference keeps time as an integer count of hundredths and converts it to digits only for the comparison.

// File: rtl/swh_pkg.sv
package swh_pkg;
   localparam int DIG_W = 4;
   typedef logic [DIG_W-1:0] bcd_t;
   typedef enum logic [1:0] {
      CMD_SAVE = 2'b00,
      CMD_WIPE = 2'b01,
      CMD_VIEW = 2'b10,
      CMD_NONE = 2'b11
   } hcmd_e;
endpackage

// File: rtl/swh_time_ctr.sv
module swh_time_ctr #(
   parameter int NDIG = 4,
   parameter bit WRAP = 1'b1,
   localparam int W = NDIG * swh_pkg::DIG_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         run,
   input  logic         clear,
   output logic [W-1:0] cur
);
   import swh_pkg::*;
   localparam logic [W-1:0] ALL_NINE = {NDIG{4'h9}};

   logic         step;
   logic [W-1:0] nxt;

   generate
      if (NDIG < 2) begin : g_bad
         $error("swh_time_ctr: NDIG must be at least 2");
      end
      if (WRAP) begin : g_wrap
         assign step = tick & run;
      end else begin : g_sat
         assign step = tick & run & (cur != ALL_NINE);
      end
   endgenerate

   always_comb begin
      logic cy;
      cy  = step;
      nxt = cur;
      for (int i = 0; i < NDIG; i++) begin
         if (cy) begin
            if (cur[i*DIG_W +: DIG_W] == bcd_t'(9)) begin
               nxt[i*DIG_W +: DIG_W] = '0;
            end else begin
               nxt[i*DIG_W +: DIG_W] = cur[i*DIG_W +: DIG_W] + bcd_t'(1);
               cy = 1'b0;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cur <= '0;
      else if (clear) cur <= '0;
      else            cur <= nxt;
   end

   // R4
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> cur == '0);
   // R3
   stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !clear) |=> $stable(cur));
   generate
      if (WRAP) begin : g_wrap_chk
         // R5
         wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (run && tick && !clear && cur == ALL_NINE) |=> cur == '0);
      end
   endgenerate
endmodule

// File: rtl/swh_hist.sv
module swh_hist #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         act,
   input  logic [1:0]   cmd,
   input  logic [W-1:0] cur,
   output logic [W-1:0] lo,
   output logic [W-1:0] hi,
   output logic         sel
);
   import swh_pkg::*;

   hcmd_e c;
   logic  empty;
   assign c = hcmd_e'(cmd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo    <= '0;
         hi    <= '0;
         empty <= 1'b1;
         sel   <= 1'b0;
      end else if (act) begin
         case (c)
            CMD_SAVE: begin
               empty <= 1'b0;
               if (empty) begin
                  lo <= cur;
                  hi <= cur;
               end else begin
                  if (cur < lo) lo <= cur;
                  if (cur > hi) hi <= cur;
               end
            end
            CMD_WIPE: begin
               lo    <= '0;
               hi    <= '0;
               empty <= 1'b1;
               sel   <= 1'b0;
            end
            CMD_VIEW: sel <= ~sel;
            default: ;
         endcase
      end
   end

   // R6
   first_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && c == CMD_SAVE && empty) |=> (lo == $past(cur) && hi == $past(cur)));
   // R7
   later_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && c == CMD_SAVE && !empty) |=> (lo <= $past(cur) && hi >= $past(cur)));
   // R7
   order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lo <= hi);
   // R8
   wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && c == CMD_WIPE) |=> (lo == '0 && hi == '0 && !sel));
   // R9
   view_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && c == CMD_VIEW) |=> sel != $past(sel));
   // R10
   none_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && c == CMD_NONE) |=> ($stable(lo) && $stable(hi) && $stable(sel)));
endmodule

// File: rtl/stopwatch_hist.sv
module stopwatch_hist #(
   parameter int NDIG = 4,
   parameter bit WRAP = 1'b1,
   localparam int W = NDIG * swh_pkg::DIG_W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         hist_mode,
   input  logic [1:0]   hist_cmd,
   input  logic         action,
   input  logic         clear,
   output logic [W-1:0] digits,
   output logic         dp_on,
   output logic         show_max
);
   import swh_pkg::*;

   logic         run;
   logic [W-1:0] cur, lo, hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    run <= 1'b0;
      else if (action && !hist_mode) run <= ~run;
   end

   swh_time_ctr #(.NDIG(NDIG), .WRAP(WRAP)) u_ctr (
      .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .clear(clear), .cur(cur)
   );

   swh_hist #(.W(W)) u_hist (
      .clk(clk), .rst_n(rst_n), .act(action & hist_mode), .cmd(hist_cmd),
      .cur(cur), .lo(lo), .hi(hi), .sel(show_max)
   );

   always_comb begin
      if (hist_mode && hcmd_e'(hist_cmd) == CMD_VIEW) digits = show_max ? hi : lo;
      else                                            digits = cur;
   end

   assign dp_on = 1'b1;

   // R3
   run_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (action && !hist_mode) |=> run != $past(run));
   // R10
   run_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hist_mode |=> run == $past(run));
endmodule

// File: tb/sim_stopwatch_hist.sv
module sim_stopwatch_hist;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0, hist_mode = 1'b0, action = 1'b0, clear = 1'b0;
   logic [1:0]  hist_cmd = 2'b00;
   logic [15:0] digits;
   logic        dp_on, show_max;

   int n_run = 0, n_fail = 0;
   bit done = 1'b0;

   // reference state
   int  m_cur = 0, m_lo = 0, m_hi = 0;
   bit  m_run = 0, m_empty = 1, m_sel = 0;

   always #5 clk = ~clk;

   stopwatch_hist u0 (
      .clk(clk), .rst_n(rst_n), .tick(tick), .hist_mode(hist_mode),
      .hist_cmd(hist_cmd), .action(action), .clear(clear),
      .digits(digits), .dp_on(dp_on), .show_max(show_max)
   );

   function automatic int to_int(input logic [15:0] d);
      return d[15:12]*1000 + d[11:8]*100 + d[7:4]*10 + d[3:0];
   endfunction

   function automatic bit bcd_ok(input logic [15:0] d);
      return d[15:12] < 10 && d[11:8] < 10 && d[7:4] < 10 && d[3:0] < 10;
   endfunction

   task automatic check(input string req);
      int exp_d;
      exp_d = (hist_mode && hist_cmd == 2'b10) ? (m_sel ? m_hi : m_lo) : m_cur;
      n_run++;
      if (!bcd_ok(digits) || to_int(digits) != exp_d) begin
         n_fail++;
         $display("FAIL %s digits: got %h expected %0d", req, digits, exp_d);
      end
      n_run++;
      if (dp_on !== 1'b1 || show_max !== m_sel) begin
         n_fail++;
         $display("FAIL %s dp/show_max: got %b/%b expected 1/%b", req, dp_on, show_max, m_sel);
      end
   endtask

   task automatic step(input string req, input bit t, input bit hm, input logic [1:0] cmd,
                       input bit act, input bit clr);
      tick = t; hist_mode = hm; hist_cmd = cmd; action = act; clear = clr;
      @(posedge clk);
      #1;
      if (hm && act) begin
         case (cmd)
            2'b00: begin
               if (m_empty) begin m_lo = m_cur; m_hi = m_cur; end
               else begin
                  if (m_cur < m_lo) m_lo = m_cur;
                  if (m_cur > m_hi) m_hi = m_cur;
               end
               m_empty = 0;
            end
            2'b01: begin m_lo = 0; m_hi = 0; m_empty = 1; m_sel = 0; end
            2'b10: m_sel = !m_sel;
            default: ;
         endcase
      end
      if (clr) m_cur = 0;
      else if (t && m_run) m_cur = (m_cur + 1) % 10000;
      if (!hm && act) m_run = !m_run;
      @(negedge clk);
      tick = 0; action = 0; clear = 0;
      check(req);
   endtask

   task automatic ticks(input string req, input int n);
      for (int i = 0; i < n; i++) step(req, 1, 0, 2'b00, 0, 0);
   endtask

   task automatic save_now(input string req);
      step(req, 0, 1, 2'b00, 1, 0);
      step(req, 0, 0, 2'b00, 0, 0);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1");
      ticks("R1", 3);                         // stopped after reset
      // R2: run and count with carries
      step("R3", 0, 0, 2'b00, 1, 0);
      ticks("R2", 123);
      // R3: stop, ticks ignored, resume from held value
      step("R3", 0, 0, 2'b00, 1, 0);
      ticks("R3", 5);
      step("R3", 0, 0, 2'b00, 1, 0);
      ticks("R3", 10);
      // R4: clear beats tick, run kept
      step("R4", 1, 0, 2'b00, 0, 1);
      ticks("R4", 7);
      step("R4", 0, 0, 2'b00, 1, 0);          // stop at 7
      // R6: first save loads both
      save_now("R6");
      step("R9", 0, 1, 2'b10, 0, 0);          // view shortest
      step("R9", 0, 1, 2'b10, 1, 0);          // view longest
      step("R9", 0, 1, 2'b10, 0, 0);
      // R7: larger time updates longest
      step("R7", 0, 0, 2'b00, 1, 0);
      ticks("R7", 50);
      step("R7", 0, 0, 2'b00, 1, 0);
      save_now("R7");
      // R7: smaller time updates shortest
      step("R7", 0, 0, 2'b00, 0, 1);
      step("R7", 0, 0, 2'b00, 1, 0);
      ticks("R7", 3);
      step("R7", 0, 0, 2'b00, 1, 0);
      save_now("R7");
      // R7: in-between time changes nothing
      step("R7", 0, 0, 2'b00, 0, 1);
      step("R7", 0, 0, 2'b00, 1, 0);
      ticks("R7", 20);
      step("R7", 0, 0, 2'b00, 1, 0);
      save_now("R7");
      step("R9", 0, 1, 2'b10, 0, 0);
      step("R9", 0, 1, 2'b10, 1, 0);
      step("R9", 0, 1, 2'b10, 1, 0);
      // R10: code 11 no effect; history actions keep the count running
      step("R10", 0, 0, 2'b00, 1, 0);         // start
      step("R10", 1, 1, 2'b11, 1, 0);
      step("R10", 1, 1, 2'b10, 0, 0);
      step("R10", 1, 1, 2'b00, 0, 0);
      ticks("R10", 4);
      step("R10", 0, 0, 2'b00, 1, 0);         // stop
      // R8: wipe, then first save again loads both
      step("R8", 0, 1, 2'b01, 1, 0);
      step("R8", 0, 1, 2'b10, 0, 0);
      save_now("R6");
      step("R6", 0, 1, 2'b10, 0, 0);
      step("R6", 0, 1, 2'b10, 1, 0);
      // R5: wrap at 99.99
      step("R5", 0, 0, 2'b00, 0, 1);
      step("R5", 0, 0, 2'b00, 1, 0);
      ticks("R2", 9999);
      ticks("R5", 3);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule